// File: doc/BRIEF.md
# Single-Block Cipher Memory Mover

This engine feeds a block cipher from system memory and writes the cipher's results back, with no processor involvement per block. Software gives it a source base address, a destination base address and a block count, then pulses a start input. The engine reads each 128-bit block as a four-beat incrementing burst on a 32-bit memory master port. It keeps the block in its only input buffer and hands it to the cipher over a valid/ready pair. Each result goes out as a four-beat write burst to the matching destination slot.

The engine reads ahead: as soon as the cipher has taken a block, the buffer is free, so the next block is fetched while the cipher works. Memory latency therefore hides behind the cipher. A buffered block is held back until the previous result has been taken for write-back, so at most one block is inside the cipher. After the last write response the engine raises a done flag. An error response on either channel, or a read burst whose last flag is out of place, stops the run and raises an error flag.

Three state machines make up the engine. The control machine has states CTL_IDLE, CTL_RUN and CTL_ABORT. CTL_IDLE goes to CTL_RUN on a start with a nonzero count, and stays in CTL_IDLE with done set on a start with a zero count. CTL_RUN goes to CTL_ABORT on an error and to CTL_IDLE on the final good write response. CTL_ABORT always goes to CTL_IDLE. The read machine steps RD_IDLE to RD_ADDR on a fetch request, RD_ADDR to RD_DATA when the address is accepted, RD_DATA to RD_FULL on the fourth beat, and RD_FULL to RD_IDLE when the cipher takes the block. The write machine steps WR_IDLE to WR_ADDR when it takes a result, WR_ADDR to WR_DATA when the address is accepted, WR_DATA to WR_RESP after the fourth beat, and WR_RESP to WR_IDLE on the response. An abort returns the read and write machines to their idle states.

Top module: `blkxfer_dma`

## Requirements
- R1: After reset, stat_busy, stat_done, stat_err, m_arvalid, m_awvalid, m_wvalid and ci_valid are all 0.
- R2: Block k of a run is read with araddr = source base + 16*k, arlen = 3, arsize = 2 and arburst = 1 (incrementing). Exactly the configured number of read bursts is issued.
- R3: ci_data carries the four read beats with the first beat in bits 31:0 and the fourth in bits 127:96. The block is offered only after its fourth beat has arrived.
- R4: Result k is written with awaddr = destination base + 16*k, with the same length, size and burst codes as reads. Beats go out in the order of R3 (bits 31:0 first), with wstrb = 4'hF and wlast high on the fourth beat only. No write beat is driven while the write address is still pending.
- R5: While the cipher holds a block, the read burst for the next block is issued.
- R6: ci_valid stays low from the cipher accepting a block until the engine has accepted that block's result.
- R7: After the configured count of write responses, stat_done goes to 1 and stat_busy to 0. stat_done stays set until the next accepted start.
- R8: A read or write response code of 2 or 3, or an rlast not on the fourth beat, ends the run. stat_busy falls, stat_err rises, stat_done stays 0 and no further bursts are issued. The next accepted start clears stat_err.
- R9: A start with a block count of zero sets stat_done on the next cycle and issues no bus traffic.
- R10: A start pulse while stat_busy is 1 is ignored, and the running job keeps its addresses and count.
- R11: A raised arvalid or wvalid stays high, with address or data unchanged, until the matching ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start pulse, taken only while idle |
| cfg_src_base | input | ADDR_W | Source base byte address |
| cfg_dst_base | input | ADDR_W | Destination base byte address |
| cfg_blocks | input | CNT_W | Number of 128-bit blocks |
| stat_busy | output | 1 | A run or abort is in progress |
| stat_done | output | 1 | Last run completed |
| stat_err | output | 1 | Last run aborted on an error |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last read beat |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response |
| ci_valid | output | 1 | Block offered to cipher |
| ci_ready | input | 1 | Cipher accepts block |
| ci_data | output | BLK_W | Block to cipher |
| co_valid | input | 1 | Cipher result valid |
| co_ready | output | 1 | Engine accepts result |
| co_data | input | BLK_W | Cipher result |

## Verification
Two things can land on the same clock edge. The fourth read beat of a prefetched block can fill the buffer in the same cycle that the previous result is accepted for write-back. The release and the refill then decide together whether ci_valid rises on the next cycle. The bench provokes this with a cipher that answers in zero or two cycles, so the read of the next block and the result handoff keep meeting. It judges the outcome by comparing every block seen on ci_data with source memory, by counting any ci_valid raised while the bench cipher still holds an unaccepted result, and by checking every destination word after the run.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_RUN,
        CTL_ABORT
    } ctl_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ADDR,
        RD_DATA,
        RD_FULL
    } rd_state_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_ADDR,
        WR_DATA,
        WR_RESP
    } wr_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;

    // Response codes 2 (slave error) and 3 (decode error) are failures.
    function automatic logic resp_failed(input logic [1:0] code);
        return (code == 2'b10) || (code == 2'b11);
    endfunction

endpackage

// File: rtl/blkxfer_rd.sv
module blkxfer_rd
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic              take,
    output logic              idle,
    output logic              full,
    output logic [BLK_W-1:0]  blk,
    output logic              bad,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast
);
    localparam int BEATS     = BLK_W / DATA_W;
    localparam int IDX_W     = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int SIZE_CODE = $clog2(DATA_W / 8);

    rd_state_e         st_q, st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              beat_fire;
    logic              beat_end;
    logic [DATA_W-1:0] lane_q [BEATS];

    assign beat_fire = (st_q == RD_DATA) && rvalid;
    assign beat_end  = beat_fire && (idx_q == IDX_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (go)       st_d = RD_ADDR;
            RD_ADDR: if (arready)  st_d = RD_DATA;
            RD_DATA: if (beat_end) st_d = RD_FULL;
            RD_FULL: if (take)     st_d = RD_IDLE;
            default:               st_d = RD_IDLE;
        endcase
        if (flush) st_d = RD_IDLE;
    end

    always_comb begin
        idle    = (st_q == RD_IDLE);
        full    = (st_q == RD_FULL);
        arvalid = (st_q == RD_ADDR);
        rready  = (st_q == RD_DATA);
        araddr  = addr_q;
        arlen   = 8'(BEATS - 1);
        arsize  = 3'(SIZE_CODE);
        arburst = BURST_INCR;
        bad     = beat_fire && (resp_failed(rresp) ||
                  (rlast != (idx_q == IDX_W'(BEATS - 1))));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            idx_q  <= '0;
        end else if ((st_q == RD_IDLE) && go) begin
            addr_q <= go_addr;
            idx_q  <= '0;
        end else if (beat_fire) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // One 32-bit lane per beat; beat g lands in bits g*DATA_W upward.
    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (beat_fire && (idx_q == IDX_W'(g))) lane_q[g] <= rdata;
        end
        assign blk[g*DATA_W +: DATA_W] = lane_q[g];
    end

    p_ar_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (arvalid && !arready) |=> (arvalid && $stable(araddr)));

    p_full_after_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(rvalid && rready));

endmodule

// File: rtl/blkxfer_wr.sv
module blkxfer_wr
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                accept,
    input  logic [ADDR_W-1:0]   go_addr,
    input  logic [BLK_W-1:0]    go_data,
    output logic                idle,
    output logic                b_ok,
    output logic                b_bad,
    output logic                awvalid,
    input  logic                awready,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [7:0]          awlen,
    output logic [2:0]          awsize,
    output logic [1:0]          awburst,
    output logic                wvalid,
    input  logic                wready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast,
    input  logic                bvalid,
    output logic                bready,
    input  logic [1:0]          bresp
);
    localparam int BEATS     = BLK_W / DATA_W;
    localparam int IDX_W     = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int SIZE_CODE = $clog2(DATA_W / 8);

    wr_state_e         st_q, st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BLK_W-1:0]  hold_q;
    logic [DATA_W-1:0] lane [BEATS];
    logic              beat_fire;
    logic              beat_end;

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        assign lane[g] = hold_q[g*DATA_W +: DATA_W];
    end

    assign beat_fire = (st_q == WR_DATA) && wready;
    assign beat_end  = beat_fire && (idx_q == IDX_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WR_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WR_IDLE: if (accept)   st_d = WR_ADDR;
            WR_ADDR: if (awready)  st_d = WR_DATA;
            WR_DATA: if (beat_end) st_d = WR_RESP;
            WR_RESP: if (bvalid)   st_d = WR_IDLE;
            default:               st_d = WR_IDLE;
        endcase
        if (flush) st_d = WR_IDLE;
    end

    always_comb begin
        idle    = (st_q == WR_IDLE);
        awvalid = (st_q == WR_ADDR);
        awaddr  = addr_q;
        awlen   = 8'(BEATS - 1);
        awsize  = 3'(SIZE_CODE);
        awburst = BURST_INCR;
        wvalid  = (st_q == WR_DATA);
        wdata   = lane[idx_q];
        wstrb   = '1;
        wlast   = (st_q == WR_DATA) && (idx_q == IDX_W'(BEATS - 1));
        bready  = (st_q == WR_RESP);
        b_ok    = (st_q == WR_RESP) && bvalid && !resp_failed(bresp);
        b_bad   = (st_q == WR_RESP) && bvalid &&  resp_failed(bresp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            idx_q  <= '0;
        end else if ((st_q == WR_IDLE) && accept) begin
            addr_q <= go_addr;
            idx_q  <= '0;
        end else if (beat_fire) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if ((st_q == WR_IDLE) && accept) hold_q <= go_data;
    end

    p_w_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast)));

    p_w_after_aw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |-> !awvalid);

endmodule

// File: rtl/blkxfer_dma.sv
module blkxfer_dma
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 128,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_start,
    input  logic [ADDR_W-1:0]   cfg_src_base,
    input  logic [ADDR_W-1:0]   cfg_dst_base,
    input  logic [CNT_W-1:0]    cfg_blocks,
    output logic                stat_busy,
    output logic                stat_done,
    output logic                stat_err,
    output logic                m_arvalid,
    input  logic                m_arready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [7:0]          m_arlen,
    output logic [2:0]          m_arsize,
    output logic [1:0]          m_arburst,
    input  logic                m_rvalid,
    output logic                m_rready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rlast,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    input  logic                m_bvalid,
    output logic                m_bready,
    input  logic [1:0]          m_bresp,
    output logic                ci_valid,
    input  logic                ci_ready,
    output logic [BLK_W-1:0]    ci_data,
    input  logic                co_valid,
    output logic                co_ready,
    input  logic [BLK_W-1:0]    co_data
);
    localparam int OFF_W = $clog2(BLK_W / 8);

    ctl_state_e        st_q, st_d;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  blocks_q;
    logic [CNT_W-1:0]  rd_cnt_q, wr_cnt_q, b_cnt_q;
    logic              inflight_q;
    logic              done_q, err_q;

    logic              run, flush, start_ok;
    logic              rd_idle, rd_full, rd_bad, rd_go, take;
    logic              wr_idle, b_ok, b_bad, accept;
    logic              err_evt, last_b;
    logic [ADDR_W-1:0] rd_addr, wr_addr;

    assign run      = (st_q == CTL_RUN);
    assign flush    = (st_q == CTL_ABORT);
    assign start_ok = (st_q == CTL_IDLE) && cfg_start;
    assign rd_go    = run && rd_idle && (rd_cnt_q != blocks_q);
    assign rd_addr  = src_q + (ADDR_W'(rd_cnt_q) << OFF_W);
    assign wr_addr  = dst_q + (ADDR_W'(wr_cnt_q) << OFF_W);
    assign take     = ci_valid && ci_ready;
    assign accept   = co_valid && co_ready;
    assign err_evt  = run && (rd_bad || b_bad);
    assign last_b   = run && b_ok && (b_cnt_q == blocks_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CTL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CTL_IDLE:  if (cfg_start && (cfg_blocks != '0)) st_d = CTL_RUN;
            CTL_RUN: begin
                if (err_evt)     st_d = CTL_ABORT;
                else if (last_b) st_d = CTL_IDLE;
            end
            CTL_ABORT:           st_d = CTL_IDLE;
            default:             st_d = CTL_IDLE;
        endcase
    end

    always_comb begin
        stat_busy = (st_q != CTL_IDLE);
        stat_done = done_q;
        stat_err  = err_q;
        ci_valid  = run && rd_full && !inflight_q;
        co_ready  = run && wr_idle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q      <= '0;
            dst_q      <= '0;
            blocks_q   <= '0;
            rd_cnt_q   <= '0;
            wr_cnt_q   <= '0;
            b_cnt_q    <= '0;
            inflight_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else if (start_ok) begin
            src_q      <= cfg_src_base;
            dst_q      <= cfg_dst_base;
            blocks_q   <= cfg_blocks;
            rd_cnt_q   <= '0;
            wr_cnt_q   <= '0;
            b_cnt_q    <= '0;
            inflight_q <= 1'b0;
            done_q     <= (cfg_blocks == '0);
            err_q      <= 1'b0;
        end else if (run) begin
            if (rd_go)   rd_cnt_q   <= rd_cnt_q + 1'b1;
            if (accept)  wr_cnt_q   <= wr_cnt_q + 1'b1;
            if (b_ok)    b_cnt_q    <= b_cnt_q + 1'b1;
            if (take)    inflight_q <= 1'b1;
            if (accept)  inflight_q <= 1'b0;
            if (err_evt) err_q      <= 1'b1;
            else if (last_b) done_q <= 1'b1;
        end else begin
            inflight_q <= 1'b0;
        end
    end

    blkxfer_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .go      (rd_go),
        .go_addr (rd_addr),
        .take    (take),
        .idle    (rd_idle),
        .full    (rd_full),
        .blk     (ci_data),
        .bad     (rd_bad),
        .arvalid (m_arvalid),
        .arready (m_arready),
        .araddr  (m_araddr),
        .arlen   (m_arlen),
        .arsize  (m_arsize),
        .arburst (m_arburst),
        .rvalid  (m_rvalid),
        .rready  (m_rready),
        .rdata   (m_rdata),
        .rresp   (m_rresp),
        .rlast   (m_rlast)
    );

    blkxfer_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .accept  (accept),
        .go_addr (wr_addr),
        .go_data (co_data),
        .idle    (wr_idle),
        .b_ok    (b_ok),
        .b_bad   (b_bad),
        .awvalid (m_awvalid),
        .awready (m_awready),
        .awaddr  (m_awaddr),
        .awlen   (m_awlen),
        .awsize  (m_awsize),
        .awburst (m_awburst),
        .wvalid  (m_wvalid),
        .wready  (m_wready),
        .wdata   (m_wdata),
        .wstrb   (m_wstrb),
        .wlast   (m_wlast),
        .bvalid  (m_bvalid),
        .bready  (m_bready),
        .bresp   (m_bresp)
    );

    p_result_needs_inflight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (co_valid && co_ready) |-> inflight_q);

    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> !stat_busy);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_err && !stat_busy) |-> (!m_arvalid && !m_awvalid && !m_wvalid));

    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_start && !stat_busy && (cfg_blocks == '0)) |=> (stat_done && !stat_busy));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_busy && cfg_start) |=> $stable(src_q) && $stable(blocks_q));

endmodule

// File: tb/blkxfer_dma_test.sv
module blkxfer_dma_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = 128;
    localparam int CW = 16;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] n;
        logic [7:0]  lat;
    } job_t;

    localparam job_t JOBS [4] = '{
        '{32'h000, 32'h300, 16'd1, 8'd44},
        '{32'h040, 32'h400, 16'd3, 8'd44},
        '{32'h100, 32'h600, 16'd5, 8'd2},
        '{32'h200, 32'h900, 16'd4, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10ns clk = ~clk;

    logic          cfg_start = 1'b0;
    logic [AW-1:0] cfg_src_base = '0, cfg_dst_base = '0;
    logic [CW-1:0] cfg_blocks = '0;
    logic          stat_busy, stat_done, stat_err;
    logic          m_arvalid, m_arready, m_rvalid, m_rready, m_rlast;
    logic [AW-1:0] m_araddr, m_awaddr;
    logic [7:0]    m_arlen, m_awlen;
    logic [2:0]    m_arsize, m_awsize;
    logic [1:0]    m_arburst, m_awburst, m_rresp, m_bresp;
    logic [DW-1:0] m_rdata, m_wdata;
    logic          m_awvalid, m_awready, m_wvalid, m_wready, m_wlast;
    logic [3:0]    m_wstrb;
    logic          m_bvalid, m_bready;
    logic          ci_valid, ci_ready, co_valid, co_ready;
    logic [BW-1:0] ci_data, co_data;

    blkxfer_dma #(.ADDR_W(AW), .DATA_W(DW), .BLK_W(BW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
        .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base), .cfg_blocks(cfg_blocks),
        .stat_busy(stat_busy), .stat_done(stat_done), .stat_err(stat_err),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
        .m_rresp(m_rresp), .m_rlast(m_rlast),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .ci_valid(ci_valid), .ci_ready(ci_ready), .ci_data(ci_data),
        .co_valid(co_valid), .co_ready(co_ready), .co_data(co_data)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] mem [0:1023];

    function automatic logic [31:0] seed_word(input int i);
        return (32'(i) * 32'h9E37_79B9) ^ {16'(i), 16'h5A5A};
    endfunction

    function automatic logic [127:0] xform(input logic [127:0] x);
        return {x[95:0], x[127:96]} ^ 128'hC3C3_0F0F_A5A5_1234_5678_9ABC_DEF0_0F1E;
    endfunction

    function automatic logic [127:0] src_block(input logic [31:0] addr);
        int w;
        w = int'(addr >> 2);
        return {mem[w+3], mem[w+2], mem[w+1], mem[w]};
    endfunction

    // ---------------- memory slave: read side ----------------
    logic        arready_r, rphase;
    logic [31:0] rd_base;
    logic [1:0]  rbeat;
    int ar_cnt = 0, rd_beat_glob = 0, rd_err_at = -1, ar_attr_bad = 0, ar_overlap = 0;
    logic [31:0] ar_log [0:255];
    int cst = 0;

    assign m_arready = arready_r;
    assign m_rvalid  = rphase;
    assign m_rdata   = mem[10'((rd_base >> 2) + 32'(rbeat))];
    assign m_rlast   = (rbeat == 2'd3);
    assign m_rresp   = (rphase && rd_beat_glob == rd_err_at) ? 2'b10 : 2'b00;

    always @(posedge clk) begin
        if (!rst_n) begin
            arready_r <= 1'b0;
            rphase    <= 1'b0;
            rbeat     <= 2'd0;
            rd_base   <= '0;
        end else begin
            arready_r <= m_arvalid && !arready_r && !rphase;
            if (m_arvalid && arready_r) begin
                rphase  <= 1'b1;
                rd_base <= m_araddr;
                rbeat   <= 2'd0;
                ar_log[ar_cnt[7:0]] <= m_araddr;
                ar_cnt  <= ar_cnt + 1;
                if (m_arlen != 8'd3 || m_arsize != 3'd2 || m_arburst != 2'd1)
                    ar_attr_bad <= ar_attr_bad + 1;
                if (cst != 0) ar_overlap <= ar_overlap + 1;
            end
            if (rphase && m_rready) begin
                rbeat        <= rbeat + 2'd1;
                rd_beat_glob <= rd_beat_glob + 1;
                if (rbeat == 2'd3) rphase <= 1'b0;
            end
        end
    end

    // ---------------- memory slave: write side ----------------
    logic        awready_r, wphase, bphase;
    logic [31:0] wr_base;
    logic [1:0]  wbeat;
    int aw_cnt = 0, b_cnt = 0, wr_err_at = -1, aw_attr_bad = 0, w_bad = 0;
    logic [31:0] aw_log [0:255];

    assign m_awready = awready_r;
    assign m_wready  = wphase;
    assign m_bvalid  = bphase;
    assign m_bresp   = (bphase && b_cnt == wr_err_at) ? 2'b10 : 2'b00;

    always @(posedge clk) begin
        if (!rst_n) begin
            awready_r <= 1'b0;
            wphase    <= 1'b0;
            bphase    <= 1'b0;
            wbeat     <= 2'd0;
            wr_base   <= '0;
        end else begin
            awready_r <= m_awvalid && !awready_r && !wphase && !bphase;
            if (m_awvalid && awready_r) begin
                wphase  <= 1'b1;
                wr_base <= m_awaddr;
                wbeat   <= 2'd0;
                aw_log[aw_cnt[7:0]] <= m_awaddr;
                aw_cnt  <= aw_cnt + 1;
                if (m_awlen != 8'd3 || m_awsize != 3'd2 || m_awburst != 2'd1)
                    aw_attr_bad <= aw_attr_bad + 1;
            end
            if (m_wvalid && wphase) begin
                mem[10'((wr_base >> 2) + 32'(wbeat))] <= m_wdata;
                if (m_wstrb != 4'hF) w_bad <= w_bad + 1;
                if (m_wlast != (wbeat == 2'd3)) w_bad <= w_bad + 1;
                wbeat <= wbeat + 2'd1;
                if (wbeat == 2'd3) begin
                    wphase <= 1'b0;
                    bphase <= 1'b1;
                end
            end
            if (bphase && m_bready) begin
                bphase <= 1'b0;
                b_cnt  <= b_cnt + 1;
            end
        end
    end

    // ---------------- cipher model: 0 idle, 1 working, 2 result waiting ----------------
    int          ccount = 0, clat = 44, in_cnt = 0, in_base = 0, in_bad = 0, early_bad = 0;
    logic [31:0] job_src = '0;
    logic [127:0] chold = '0;

    assign ci_ready = (cst == 0);
    assign co_valid = (cst == 2);
    assign co_data  = chold;

    always @(posedge clk) begin
        if (!rst_n) begin
            cst <= 0;
        end else begin
            if (ci_valid && cst != 0) early_bad <= early_bad + 1;
            case (cst)
                0: if (ci_valid) begin
                    if (ci_data != src_block(job_src + 32'((in_cnt - in_base) * 16)))
                        in_bad <= in_bad + 1;
                    in_cnt <= in_cnt + 1;
                    chold  <= xform(ci_data);
                    ccount <= clat;
                    cst    <= (clat == 0) ? 2 : 1;
                end
                1: begin
                    ccount <= ccount - 1;
                    if (ccount <= 1) cst <= 2;
                end
                default: if (co_ready) cst <= 0;
            endcase
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            summary_and_end();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        chk(!stat_busy && !stat_done && !stat_err, "R1", {tag, " status"},
            {stat_busy, stat_done, stat_err}, 0);
        chk(!m_arvalid && !m_awvalid && !m_wvalid && !ci_valid, "R1", {tag, " valids"},
            {m_arvalid, m_awvalid, m_wvalid, ci_valid}, 0);
    endtask

    task automatic kick(input logic [31:0] src, input logic [31:0] dst,
                        input logic [15:0] n, input int lat);
        @(negedge clk);
        cfg_src_base = src;
        cfg_dst_base = dst;
        cfg_blocks   = n;
        clat         = lat;
        job_src      = src;
        in_base      = in_cnt;
        cfg_start    = 1'b1;
        @(negedge clk);
        cfg_start    = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            if (!stat_busy) break;
            @(negedge clk);
        end
    endtask

    task automatic check_job(input logic [31:0] src, input logic [31:0] dst,
                             input int n, input int ar0, input int aw0);
        logic [127:0] x;
        chk(stat_done && !stat_err && !stat_busy, "R7", "done after run",
            {stat_busy, stat_done, stat_err}, 3'b010);
        chk(ar_cnt - ar0 == n, "R2", "read burst count", ar_cnt - ar0, n);
        chk(aw_cnt - aw0 == n, "R4", "write burst count", aw_cnt - aw0, n);
        for (int k = 0; k < n; k++) begin
            chk(ar_log[8'(ar0 + k)] == src + 32'(16 * k), "R2", "read address",
                ar_log[8'(ar0 + k)], src + 32'(16 * k));
            chk(aw_log[8'(aw0 + k)] == dst + 32'(16 * k), "R4", "write address",
                aw_log[8'(aw0 + k)], dst + 32'(16 * k));
            x = xform(src_block(src + 32'(16 * k)));
            for (int j = 0; j < 4; j++) begin
                chk(mem[int'(dst >> 2) + 4 * k + j] == x[32*j +: 32], "R3", "stored word order",
                    mem[int'(dst >> 2) + 4 * k + j], x[32*j +: 32]);
            end
        end
    endtask

    int ar0, aw0, attr0, wb0, inb0, early0, ovl0, hold;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = seed_word(i);
        repeat (3) @(negedge clk);
        check_reset_state("after reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("first cycle");

        // Table of jobs walked by one loop
        for (int t = 0; t < 4; t++) begin
            ar0 = ar_cnt; aw0 = aw_cnt; attr0 = ar_attr_bad + aw_attr_bad;
            wb0 = w_bad; inb0 = in_bad; early0 = early_bad; ovl0 = ar_overlap;
            kick(JOBS[t].src, JOBS[t].dst, JOBS[t].n, int'(JOBS[t].lat));
            wait_end();
            check_job(JOBS[t].src, JOBS[t].dst, int'(JOBS[t].n), ar0, aw0);
            chk(ar_attr_bad + aw_attr_bad == attr0, "R2", "burst codes", ar_attr_bad + aw_attr_bad, attr0);
            chk(w_bad == wb0, "R4", "strobe and last beat", w_bad, wb0);
            chk(in_bad == inb0, "R3", "block on ci_data", in_bad, inb0);
            chk(early_bad == early0, "R6", "offer before release", early_bad, early0);
            if (JOBS[t].n >= 2 && JOBS[t].lat >= 8)
                chk(ar_overlap > ovl0, "R5", "read during cipher work", ar_overlap - ovl0, 1);
            repeat (3) @(negedge clk);
            chk(stat_done, "R7", "done held", stat_done, 1);
        end

        // R9: zero-count start
        ar0 = ar_cnt; aw0 = aw_cnt;
        kick(32'h000, 32'hE00, 16'd0, 4);
        chk(stat_done && !stat_busy, "R9", "zero count done", {stat_busy, stat_done}, 2'b01);
        repeat (20) @(negedge clk);
        chk(ar_cnt == ar0 && aw_cnt == aw0, "R9", "zero count traffic",
            (ar_cnt - ar0) + (aw_cnt - aw0), 0);

        // R10: start while busy is ignored
        ar0 = ar_cnt; aw0 = aw_cnt;
        kick(32'h080, 32'hB00, 16'd2, 44);
        repeat (5) @(negedge clk);
        cfg_src_base = 32'h700; cfg_dst_base = 32'hA00; cfg_blocks = 16'd6;
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_end();
        check_job(32'h080, 32'hB00, 2, ar0, aw0);

        // R8: read error on the last beat of the second block
        ar0 = ar_cnt; aw0 = aw_cnt;
        rd_err_at = rd_beat_glob + 7;
        kick(32'h000, 32'hC00, 16'd4, 44);
        wait_end();
        chk(stat_err && !stat_done && !stat_busy, "R8", "read error status",
            {stat_busy, stat_done, stat_err}, 3'b001);
        hold = ar_cnt;
        repeat (100) @(negedge clk);
        chk(ar_cnt == hold && aw_cnt == aw0, "R8", "no bursts after read abort",
            (ar_cnt - hold) + (aw_cnt - aw0), 0);
        rd_err_at = -1;
        kick(32'h000, 32'hE00, 16'd0, 4);
        chk(!stat_err && stat_done, "R8", "start clears error", {stat_done, stat_err}, 2'b10);
        do_reset();
        check_reset_state("after abort reset");

        // R8: write error on the first response
        ar0 = ar_cnt; aw0 = aw_cnt;
        wr_err_at = b_cnt;
        kick(32'h100, 32'hD00, 16'd3, 10);
        wait_end();
        chk(stat_err && !stat_done && !stat_busy, "R8", "write error status",
            {stat_busy, stat_done, stat_err}, 3'b001);
        repeat (100) @(negedge clk);
        chk(aw_cnt - aw0 == 1, "R8", "no writes after write abort", aw_cnt - aw0, 1);
        wr_err_at = -1;
        do_reset();
        check_reset_state("end reset");

        summary_and_end();
    end
endmodule